// File: doc/BRIEF.md
# Core Wait-Condition Sleep Unit

This unit sits beside one processing core and stops instruction issue until one chosen condition holds. The core fires a single-cycle start strobe together with a wait kind, a target operand and a mask operand. For a counter wait, the unit compares the shared free-running system counter against the target. For a pin wait, it compares the input pins against the target, looking only at the bits the mask selects.

While the condition is unmet, the unit holds `stall_o` high. The core uses that level both to freeze issue and to enter its low-power state. On the first clock edge where the condition is seen true, the unit drops the stall and pulses `resume_o` for exactly one cycle. Wake-up therefore lands on an exact master-clock edge and is not rounded to instruction boundaries.

Only one condition can be armed at a time. A wait with no pending match never ends: there is no timeout and no combined counter-plus-pin wait.

Top module: `wait_sleep_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `stall_o` and `resume_o` are both low.
- R2: A `start_i` pulse sampled while the unit is not stalling arms the unit, and `stall_o` is high from the next cycle.
- R3: In a counter wait (`kind_i` = 0), the unit stays stalled until the clock edge at which `sys_cnt_i` equals the target. In the cycle after that edge, `stall_o` is low and `resume_o` is high.
- R4: Counter equality is modulo 2^32. A target numerically below the counter value at arm time is reached after the counter wraps through zero, with no extra delay.
- R5: In a pin wait (`kind_i` = 1), the condition holds when (`pins_i` AND mask) equals (target AND mask). Pins outside the mask never affect the outcome.
- R6: If the condition is already true at the first edge after arming, `stall_o` is high for exactly one cycle, followed by `resume_o`.
- R7: A `start_i` pulse that arrives while `stall_o` is high is ignored. The original condition still decides when the unit wakes.
- R8: A pin wait with an all-zero mask is satisfied immediately, as in R6.
- R9: `resume_o` is a single-cycle pulse and is never high together with `stall_o`.
- R10: Without a start strobe, `stall_o` and `resume_o` stay low whatever the counter and pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle strobe that arms a wait |
| kind_i | input | 1 | Wait kind: 0 = counter reaches target, 1 = masked pins match |
| target_i | input | 32 | Counter target value or required pin pattern |
| mask_i | input | 32 | Pin select mask for a pin wait (1 = compared) |
| sys_cnt_i | input | 32 | Free-running system counter |
| pins_i | input | 32 | Pin input states |
| stall_o | output | 1 | Core held and sleeping |
| resume_o | output | 1 | One-cycle pulse marking the cycle execution resumes |

## Verification
The hardest situations to produce are a match that lands on the very first evaluated edge, and a second strobe that arrives mid-wait. From the ports alone, neither is visible except through the exact cycle in which `resume_o` rises.

The bench preloads the counter just below the wrap point and computes each expected wake cycle as the 32-bit difference between target and counter. For pin waits, it builds patterns that differ from the target only in unmasked bits, or only in one masked bit, and switches pins on a chosen cycle. The stray strobe used against R7 carries an all-zero pin mask. If the unit accepted it, the wake would move several cycles early.

// File: rtl/waitu_pkg.sv
package waitu_pkg;

    // Operand, counter and pin width
    parameter int unsigned WU_W = 32;

    typedef enum logic {
        KIND_COUNT = 1'b0,
        KIND_PINS  = 1'b1
    } wait_kind_e;

    typedef struct packed {
        wait_kind_e            kind;
        logic [WU_W-1:0]       target;
        logic [WU_W-1:0]       mask;
    } wait_req_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SLEEP = 2'd1,
        SEQ_WAKE  = 2'd2
    } seq_state_e;

    // Equality is modulo 2^WU_W, so wrap needs no special case
    function automatic logic count_reached(input logic [WU_W-1:0] now_v,
                                           input logic [WU_W-1:0] tgt_v);
        return now_v == tgt_v;
    endfunction

endpackage

// File: rtl/wu_req_reg.sv
module wu_req_reg
    import waitu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      capture_i,
    input  wait_req_t d_i,
    output wait_req_t q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (capture_i) begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/wu_match.sv
module wu_match
    import waitu_pkg::*;
#(
    parameter int unsigned W = WU_W
) (
    input  wait_req_t      req_i,
    input  logic [W-1:0]   sys_cnt_i,
    input  logic [W-1:0]   pins_i,
    output logic           hit_o
);
    logic [W-1:0] bit_miss;

    // One masked comparator per pin
    for (genvar i = 0; i < W; i++) begin : g_pin
        assign bit_miss[i] = req_i.mask[i] & (pins_i[i] ^ req_i.target[i]);
    end

    always_comb begin
        unique case (req_i.kind)
            KIND_COUNT: hit_o = count_reached(sys_cnt_i, req_i.target);
            KIND_PINS:  hit_o = ~|bit_miss;
            default:    hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/wu_seq.sv
module wu_seq
    import waitu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic hit_i,
    output logic capture_o,
    output logic stall_o,
    output logic resume_o
);
    seq_state_e state_q, state_d;

    // A strobe is only taken when no wait is in progress
    assign capture_o = start_i && (state_q != SEQ_SLEEP);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (start_i) state_d = SEQ_SLEEP;
            SEQ_SLEEP: if (hit_i)   state_d = SEQ_WAKE;
            SEQ_WAKE:  state_d = start_i ? SEQ_SLEEP : SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign stall_o  = (state_q == SEQ_SLEEP);
    assign resume_o = (state_q == SEQ_WAKE);
endmodule

// File: rtl/wait_sleep_unit.sv
module wait_sleep_unit
    import waitu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic            kind_i,
    input  logic [WU_W-1:0] target_i,
    input  logic [WU_W-1:0] mask_i,
    input  logic [WU_W-1:0] sys_cnt_i,
    input  logic [WU_W-1:0] pins_i,
    output logic            stall_o,
    output logic            resume_o
);
    wait_req_t req_d, req_q;
    logic      capture;
    logic      cond_hit;

    always_comb begin
        req_d.kind   = wait_kind_e'(kind_i);
        req_d.target = target_i;
        req_d.mask   = mask_i;
    end

    wu_req_reg u_req (
        .clk       (clk),
        .rst       (rst),
        .capture_i (capture),
        .d_i       (req_d),
        .q_o       (req_q)
    );

    wu_match #(.W(WU_W)) u_match (
        .req_i     (req_q),
        .sys_cnt_i (sys_cnt_i),
        .pins_i    (pins_i),
        .hit_o     (cond_hit)
    );

    wu_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .hit_i     (cond_hit),
        .capture_o (capture),
        .stall_o   (stall_o),
        .resume_o  (resume_o)
    );
endmodule

// File: rtl/wu_sleep_chk.sv
module wu_sleep_chk
    import waitu_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      start_i,
    input logic      stall_o,
    input logic      resume_o,
    input logic      hit,
    input wait_req_t req_q
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!stall_o && !resume_o));

    // R2
    arm_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !stall_o) |=> stall_o);

    // R3
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        (stall_o && hit) |=> (resume_o && !stall_o));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stall_o && !hit) |=> stall_o);

    // R3
    resume_src_chk: assert property (@(posedge clk) disable iff (rst)
        resume_o |-> $past(stall_o && hit));

    // R7
    ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> $stable(req_q));

    // R9
    resume_single_chk: assert property (@(posedge clk) disable iff (rst)
        resume_o |=> !resume_o);
endmodule

bind wait_sleep_unit wu_sleep_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .stall_o  (stall_o),
    .resume_o (resume_o),
    .hit      (cond_hit),
    .req_q    (req_q)
);

// File: tb/wait_sleep_unit_test.sv
module wait_sleep_unit_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst, start, kind;
    logic [W-1:0] target, mask, pins, sys_cnt, load_val;
    logic         load_en;
    logic         stall_o, resume_o;
    int           checks = 0;
    int           fails  = 0;
    bit           done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    // Free-running counter model, preloadable by the bench
    always @(posedge clk) begin
        if (rst)          sys_cnt <= '0;
        else if (load_en) sys_cnt <= load_val;
        else              sys_cnt <= sys_cnt + 1;
    end

    wait_sleep_unit uut (
        .clk(clk), .rst(rst), .start_i(start), .kind_i(kind),
        .target_i(target), .mask_i(mask), .sys_cnt_i(sys_cnt),
        .pins_i(pins), .stall_o(stall_o), .resume_o(resume_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic load_cnt(input logic [W-1:0] v);
        load_en = 1'b1; load_val = v;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    // Called at a negedge; counts cycles from arming until resume_o
    task automatic do_wait(input bit k, input logic [W-1:0] tgt,
                           input logic [W-1:0] msk, input logic [W-1:0] p0,
                           input logic [W-1:0] p1, input int d,
                           input bit intrude, input int exp_j,
                           input string req);
        int n;
        bit stall_ok;
        pins = p0; kind = k; target = tgt; mask = msk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0; stall_ok = 1'b1;
        while (!resume_o && n < exp_j + 20) begin
            if (!stall_o) stall_ok = 1'b0;
            if (n == d) pins = p1;
            if (intrude && n == 1) begin
                start = 1'b1; kind = 1'b1; mask = '0; target = '0;
            end
            if (intrude && n == 2) start = 1'b0;
            n++;
            @(negedge clk);
        end
        chk(n == exp_j, req, "resume cycle", n, exp_j);
        chk(stall_ok, req, "stall held while waiting", stall_ok, 1);
        chk(!stall_o, "R9", "stall in resume cycle", stall_o, 0);
        @(negedge clk);
        chk(!resume_o, "R9", "resume width", resume_o, 0);
        chk(!stall_o, "R10", "idle after resume", stall_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R10 watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] c, r, m, t, lowbit;
        rst = 1'b1; start = 1'b0; kind = 1'b0; target = '0; mask = '0;
        pins = '0; load_en = 1'b0; load_val = '0;
        repeat (3) @(negedge clk);
        chk(!stall_o && !resume_o, "R1", "outputs in reset", {stall_o, resume_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!stall_o && !resume_o, "R1", "outputs after reset", {stall_o, resume_o}, 0);

        // R10: no strobe, counter and pins moving
        for (int i = 0; i < 8; i++) begin
            pins = 32'h1 << (i * 3); target = sys_cnt + 1; mask = '1;
            @(negedge clk);
            chk(!stall_o && !resume_o, "R10", "idle outputs", {stall_o, resume_o}, 0);
        end

        // R2 R3: counter waits at many offsets; offset 1 is R6
        for (int off = 1; off <= 24; off++) begin
            c = sys_cnt;
            do_wait(1'b0, c + off, '0, '0, '0, 1000, 1'b0, off,
                    (off == 1) ? "R6" : "R3");
        end
        c = sys_cnt;
        do_wait(1'b0, c + 500, '0, '0, '0, 1000, 1'b0, 500, "R2");

        // R4: wrap through zero
        load_cnt(32'hFFFF_FFF8);
        c = sys_cnt;
        do_wait(1'b0, 32'h0000_0004, '0, '0, '0, 1000, 1'b0,
                int'(32'h0000_0004 - c), "R4");
        load_cnt(32'hFFFF_FFFE);
        c = sys_cnt;
        do_wait(1'b0, 32'h0000_0000, '0, '0, '0, 1000, 1'b0,
                int'(32'h0 - c), "R4");

        // R5 R6: pin waits over generated patterns
        r = 32'hACE1_1234;
        for (int i = 0; i < 24; i++) begin
            r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
            m = r | 32'h1;
            r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
            t = r;
            // only unmasked bits differ: already true
            do_wait(1'b1, t, m, t ^ (~m & r ^ 32'h5A5A_0000 & ~m), '0, 1000,
                    1'b0, 1, "R5");
            // one masked bit wrong, fixed after 3 cycles
            lowbit = m & (~m + 1);
            do_wait(1'b1, t, m, t ^ lowbit, t ^ (~m), 3, 1'b0, 4, "R5");
        end

        // R8: empty mask
        do_wait(1'b1, 32'hFFFF_0000, '0, 32'h0000_FFFF, '0, 1000, 1'b0, 1, "R8");

        // R7: stray strobe mid-wait with an instantly true pin condition
        c = sys_cnt;
        do_wait(1'b0, c + 8, '0, '0, '0, 1000, 1'b1, 8, "R7");
        c = sys_cnt;
        do_wait(1'b0, c + 30, '0, '0, '0, 1000, 1'b1, 30, "R7");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule